// File: doc/BRIEF.md
# Exception Request Prioritizer

This block sits beside the control unit of a small processor core and decides which pending exception the core takes next. It collects seven kinds of request: reset, illegal opcode, trace, address error, interrupt, sleep instruction and trap instruction. Each cycle it names at most one winner, chosen by a fixed ranking. Reset and illegal-opcode requests are served at once. The other five wait for an instruction boundary, which the control unit marks with a one-cycle completion strobe.

The completion strobe comes with two qualifiers. One says the finished instruction was a return-from-exception. The other says it wrote the condition or control register. These qualifiers, the trace bit, the interrupt control mode and the two standby-control bits decide whether a source may compete at all. A request that loses to a higher one stays pending and is served at a later opportunity. The winner is reported as a registered one-cycle pulse: a one-hot vector plus a 3-bit code. A synchronous clear input drops every pending request except reset.

Top module: `exc_prioritizer`

## Requirements
- R1: The ranking from highest to lowest is reset, illegal opcode, trace, address error, interrupt, sleep, trap. Their codes are 0 to 6 in that order. Source n drives `grant[n]`, and `grant_id` equals n.
- R2: Among the sources eligible in a cycle, only the highest-ranked one is granted. Every loser is served later, in ranking order, and no request is lost.
- R3: A reset request is latched on a low-to-high transition of `rst_pin` or on a `wdt_ovf` pulse. `core_hold` is high while `rst_pin` is low. A latched reset is granted at the next clock edge, whether or not an instruction completes.
- R4: A pulse on `illegal_op` is latched and granted at the next clock edge without waiting for an instruction boundary.
- R5: Trace is requested at an edge where `insn_done` is high, `trace_bit` is 1, `icm` equals 2'b10 and `done_rte` is 0. If it wins, it is granted at that same edge. If it loses, it stays pending for the next boundary.
- R6: A pulse on `addr_err` is latched. It is granted only at a later edge where `insn_done` is high, and never without a completion.
- R7: The level on `irq_req` may win only at an edge where `insn_done` is high and `done_ctl_wr` is 0. It also may not win at the first completion after a reset grant.
- R8: `sleep_exec` creates a request only when `stby_sel` is 0 and `slp_ie` is 1. With any other setting of these two bits it has no effect.
- R9: `sleep_exec` and `trap_exec` pulses are latched in any cycle. They are granted at a completion edge later than the one that latched them.
- R10: Each grant lasts exactly one cycle. It is visible from the edge where the source won until the next edge. The winner's pending flag clears at that same edge.
- R11: `clr_pend` high at an edge drops every pending request except reset, including requests arriving that cycle, and allows only a reset grant at that edge.
- R12: While `rst_n` is low at an edge, all pending flags clear, `grant` is 0, `grant_id` is 0 and `grant_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| rst_pin | input | 1 | Reset pin level; its rising edge requests reset |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| illegal_op | input | 1 | Undefined opcode executed |
| addr_err | input | 1 | Address error pulse from the bus unit |
| trace_bit | input | 1 | Trace enable bit |
| icm | input | 2 | Interrupt control mode |
| irq_req | input | 1 | Masked interrupt request level |
| sleep_exec | input | 1 | Sleep instruction executed |
| stby_sel | input | 1 | Software-standby select bit |
| slp_ie | input | 1 | Sleep-interrupt enable bit |
| trap_exec | input | 1 | Trap instruction executed |
| insn_done | input | 1 | Instruction or exception handling complete |
| done_rte | input | 1 | Completed instruction was a return-from-exception |
| done_ctl_wr | input | 1 | Completed instruction wrote the condition or control register |
| clr_pend | input | 1 | Clear all pending requests except reset |
| grant | output | 7 | One-hot grant, registered |
| grant_id | output | 3 | Code of the granted source |
| grant_valid | output | 1 | A grant is present this cycle |
| core_hold | output | 1 | Core held in reset while the pin is low |

## Verification
The assertions assume that `done_rte` and `done_ctl_wr` are meaningful only together with `insn_done`. They also assume that the interrupt source drops `irq_req` once its grant has been seen. The stimulus drives the qualifiers only in completion cycles. It drops the interrupt level on the cycle after a code-4 grant, so no single interrupt is taken twice. Strobes are one-cycle pulses driven between edges, and the bench keeps `clr_pend` low except in the clear tests.

// File: rtl/exc_prio_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the exception prioritizer.
// Assumes a fixed set of seven sources ranked by index, index 0 highest.
package exc_prio_pkg;
    localparam int NSRC = 7;
    localparam int IDW  = $clog2(NSRC);

    localparam int IDX_RESET   = 0;
    localparam int IDX_ILLEGAL = 1;
    localparam int IDX_TRACE   = 2;
    localparam int IDX_ADDR    = 3;
    localparam int IDX_IRQ     = 4;
    localparam int IDX_SLEEP   = 5;
    localparam int IDX_TRAP    = 6;

    // Sources served without waiting for an instruction boundary.
    localparam logic [NSRC-1:0] IMMEDIATE_MASK = 7'b000_0011;
    // Sources that hold a pending flag (the interrupt is a live level).
    localparam logic [NSRC-1:0] LATCHED_MASK   = 7'b110_1111;
endpackage

// File: rtl/exc_src_qualify.sv
`timescale 1ns/1ps
// Module: exc_src_qualify
// Turns raw strobes and context bits into per-source request terms:
// "set" terms go into pending flags, "live" terms compete in the current
// cycle only. Keeps the reset-pin edge detector and the flag that blocks
// interrupts on the first completion after a reset grant.
// Assumes rst_pin is already synchronous to clk.
module exc_src_qualify
    import exc_prio_pkg::*;
#(
    parameter int          MODE_W     = 2,
    parameter logic [MODE_W-1:0] TRACE_MODE = MODE_W'(2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_pin,
    input  logic              wdt_ovf,
    input  logic              illegal_op,
    input  logic              addr_err,
    input  logic              trace_bit,
    input  logic [MODE_W-1:0] icm,
    input  logic              irq_req,
    input  logic              sleep_exec,
    input  logic              stby_sel,
    input  logic              slp_ie,
    input  logic              trap_exec,
    input  logic              insn_done,
    input  logic              done_rte,
    input  logic              done_ctl_wr,
    input  logic              reset_won,
    output logic [NSRC-1:0]   set_req,
    output logic [NSRC-1:0]   live_req
);
    logic pin_q;
    logic after_rst;
    logic trace_now;

    // Remember the previous pin level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= rst_pin;
    end

    // Mark the span between a reset grant and the next completion.
    always_ff @(posedge clk) begin
        if (!rst_n)         after_rst <= 1'b0;
        else if (reset_won) after_rst <= 1'b1;
        else if (insn_done) after_rst <= 1'b0;
    end

    assign trace_now = insn_done & trace_bit & (icm == TRACE_MODE) & ~done_rte;

    // Build the latched request terms per source.
    always_comb begin
        set_req              = '0;
        set_req[IDX_RESET]   = (rst_pin & ~pin_q) | wdt_ovf;
        set_req[IDX_ILLEGAL] = illegal_op;
        set_req[IDX_TRACE]   = trace_now;
        set_req[IDX_ADDR]    = addr_err;
        set_req[IDX_SLEEP]   = sleep_exec & ~stby_sel & slp_ie;
        set_req[IDX_TRAP]    = trap_exec;
    end

    // Build the terms that compete in this cycle without latching first.
    always_comb begin
        live_req            = '0;
        live_req[IDX_TRACE] = trace_now;
        live_req[IDX_IRQ]   = irq_req & ~done_ctl_wr & ~after_rst;
    end

    // R7: no interrupt term on a completion that wrote the control register
    assert_irq_ctl_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && done_ctl_wr) |-> !live_req[IDX_IRQ]);
endmodule

// File: rtl/exc_pend_bank.sv
`timescale 1ns/1ps
// Module: exc_pend_bank
// One pending flag per source. A flag sets on its request term, clears
// when its source wins, and (except reset) clears on the clear input.
// Sources outside LATCHED keep a constant-zero flag.
module exc_pend_bank
    import exc_prio_pkg::*;
#(
    parameter logic [NSRC-1:0] LATCHED = LATCHED_MASK
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_req,
    input  logic [NSRC-1:0] win,
    input  logic            clr_pend,
    output logic [NSRC-1:0] pend
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic q;
        logic d;

        // Next state of this source's pending flag.
        always_comb begin
            d = (q | set_req[i]) & ~win[i] & LATCHED[i];
            if (i != IDX_RESET && clr_pend) d = 1'b0;
        end

        // Hold the pending flag.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= d;
        end

        assign pend[i] = q;
    end

    // R11: clear empties every flag but reset
    assert_clear_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend |=> (pend[NSRC-1:1] == '0));
endmodule

// File: rtl/exc_prio_pick.sv
`timescale 1ns/1ps
// Module: exc_prio_pick
// Gates pending and live terms by boundary and clear rules, then selects
// the lowest-index eligible source. Purely combinational.
module exc_prio_pick
    import exc_prio_pkg::*;
#(
    parameter logic [NSRC-1:0] IMMEDIATE = IMMEDIATE_MASK
) (
    input  logic            insn_done,
    input  logic            clr_pend,
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] live_req,
    output logic [NSRC-1:0] win,
    output logic [IDW-1:0]  win_id
);
    logic [NSRC-1:0] elig;
    logic [NSRC:0]   taken;

    // Decide which sources may compete this cycle.
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            elig[i] = pend[i] | live_req[i];
            if (!IMMEDIATE[i]) elig[i] = elig[i] & insn_done;
            if (i != IDX_RESET) elig[i] = elig[i] & ~clr_pend;
        end
    end

    assign taken[0] = 1'b0;
    for (genvar i = 0; i < NSRC; i++) begin : g_chain
        assign win[i]     = elig[i] & ~taken[i];
        assign taken[i+1] = taken[i] | elig[i];
    end

    // Encode the one-hot winner.
    always_comb begin
        win_id = '0;
        for (int i = 0; i < NSRC; i++)
            if (win[i]) win_id = IDW'(i);
    end
endmodule

// File: rtl/exc_prioritizer.sv
`timescale 1ns/1ps
// Module: exc_prioritizer (top)
// Fixed-priority selection of CPU exception requests with a registered
// one-cycle grant. Assumes done_rte and done_ctl_wr qualify insn_done and
// that the interrupt source drops irq_req once its grant is seen.
module exc_prioritizer
    import exc_prio_pkg::*;
#(
    parameter int                MODE_W     = 2,
    parameter logic [MODE_W-1:0] TRACE_MODE = MODE_W'(2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_pin,
    input  logic              wdt_ovf,
    input  logic              illegal_op,
    input  logic              addr_err,
    input  logic              trace_bit,
    input  logic [MODE_W-1:0] icm,
    input  logic              irq_req,
    input  logic              sleep_exec,
    input  logic              stby_sel,
    input  logic              slp_ie,
    input  logic              trap_exec,
    input  logic              insn_done,
    input  logic              done_rte,
    input  logic              done_ctl_wr,
    input  logic              clr_pend,
    output logic [NSRC-1:0]   grant,
    output logic [IDW-1:0]    grant_id,
    output logic              grant_valid,
    output logic              core_hold
);
    logic [NSRC-1:0] set_req;
    logic [NSRC-1:0] live_req;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] win;
    logic [IDW-1:0]  win_id;

    exc_src_qualify #(.MODE_W(MODE_W), .TRACE_MODE(TRACE_MODE)) u_qual (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .wdt_ovf(wdt_ovf),
        .illegal_op(illegal_op), .addr_err(addr_err), .trace_bit(trace_bit),
        .icm(icm), .irq_req(irq_req), .sleep_exec(sleep_exec),
        .stby_sel(stby_sel), .slp_ie(slp_ie), .trap_exec(trap_exec),
        .insn_done(insn_done), .done_rte(done_rte), .done_ctl_wr(done_ctl_wr),
        .reset_won(win[IDX_RESET]), .set_req(set_req), .live_req(live_req)
    );

    exc_pend_bank #(.LATCHED(LATCHED_MASK)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .win(win),
        .clr_pend(clr_pend), .pend(pend)
    );

    exc_prio_pick #(.IMMEDIATE(IMMEDIATE_MASK)) u_pick (
        .insn_done(insn_done), .clr_pend(clr_pend), .pend(pend),
        .live_req(live_req), .win(win), .win_id(win_id)
    );

    // Register the winner as a one-cycle grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant       <= '0;
            grant_id    <= '0;
            grant_valid <= 1'b0;
        end else begin
            grant       <= win;
            grant_id    <= win_id;
            grant_valid <= |win;
        end
    end

    assign core_hold = ~rst_pin;

    // R2: at most one source granted
    assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R1: code and one-hot vector agree
    assert_id_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant == (NSRC'(1) << grant_id)));
    // R10: boundary sources are granted only on a completion edge
    assert_boundary_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant[NSRC-1:IDX_TRACE]) |-> $past(insn_done));
    // R5: no fresh trace outside the trace mode or after a return
    assert_trace_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend[IDX_TRACE] && (icm != TRACE_MODE || done_rte)) |=> !grant[IDX_TRACE]);
    // R7: control-register write blocks the interrupt at that boundary
    assert_irq_after_ctl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && done_ctl_wr) |=> !grant[IDX_IRQ]);
    // R8: a sleep with the wrong standby bits leaves nothing pending
    assert_sleep_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend[IDX_SLEEP] && sleep_exec && (stby_sel || !slp_ie)) |=> !pend[IDX_SLEEP]);
endmodule

// File: tb/exc_prioritizer_tb.sv
`timescale 1ns/1ps
module exc_prioritizer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_pin = 1'b1, wdt_ovf = 0, illegal_op = 0, addr_err = 0;
    logic trace_bit = 0, irq_req = 0, sleep_exec = 0, stby_sel = 0, slp_ie = 1;
    logic trap_exec = 0, insn_done = 0, done_rte = 0, done_ctl_wr = 0, clr_pend = 0;
    logic [1:0] icm = 2'd0;
    logic [6:0] grant;
    logic [2:0] grant_id;
    logic       grant_valid, core_hold;

    int total = 0;
    int bad   = 0;
    int expq[$];
    bit irq_acked = 0;
    bit finished  = 0;

    always #4 clk = ~clk;

    exc_prioritizer u_dut (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .wdt_ovf(wdt_ovf),
        .illegal_op(illegal_op), .addr_err(addr_err), .trace_bit(trace_bit),
        .icm(icm), .irq_req(irq_req), .sleep_exec(sleep_exec),
        .stby_sel(stby_sel), .slp_ie(slp_ie), .trap_exec(trap_exec),
        .insn_done(insn_done), .done_rte(done_rte), .done_ctl_wr(done_ctl_wr),
        .clr_pend(clr_pend), .grant(grant), .grant_id(grant_id),
        .grant_valid(grant_valid), .core_hold(core_hold)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pop the expected code for every grant the design produces.
    always @(posedge clk) begin
        #1;
        if (rst_n && grant_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R2 unexpected grant", int'(grant_id), -1);
            end else begin
                int e;
                e = expq.pop_front();
                chk(grant_id == 3'(e) && grant == (7'd1 << e), "R1 grant order",
                    int'(grant_id), e);
            end
            if (grant_id == 3'd4) irq_acked = 1'b1;
        end
    end

    task automatic quiet();
        wdt_ovf = 0; illegal_op = 0; addr_err = 0; sleep_exec = 0;
        trap_exec = 0; insn_done = 0; done_rte = 0; done_ctl_wr = 0; clr_pend = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); quiet(); end
    endtask

    // Sample just after the next edge.
    task automatic after_edge();
        @(posedge clk); #2;
    endtask

    task automatic strobe(input int s);
        case (s)
            0: wdt_ovf = 1;
            1: illegal_op = 1;
            3: addr_err = 1;
            5: sleep_exec = 1;
            6: trap_exec = 1;
            default: ;
        endcase
    endtask

    // Driver: make sources a and b pending together; expect a then b.
    task automatic run_pair(input int a, input int b);
        irq_acked = 0;
        expq.push_back(a);
        expq.push_back(b);
        @(negedge clk); quiet(); strobe(a); strobe(b);
        @(negedge clk); quiet(); insn_done = 1;
        if (a == 2 || b == 2) begin trace_bit = 1; icm = 2'd2; end
        if (a == 4 || b == 4) irq_req = 1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); quiet(); trace_bit = 0; insn_done = 1;
            if (irq_acked) irq_req = 0;
        end
        @(negedge clk); quiet(); irq_req = 0; icm = 2'd0;
        idle(2);
    endtask

    initial begin
        #1200000;
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1;
        after_edge();
        // R12: reset state
        chk(grant_valid == 0 && grant == 0 && grant_id == 0, "R12 reset state", int'(grant), 0);
        chk(core_hold == 0, "R3 core_hold with pin high", int'(core_hold), 0);

        // R4: illegal opcode granted at the next edge with no completion
        expq.push_back(1);
        @(negedge clk); illegal_op = 1;
        @(negedge clk); quiet();
        after_edge();
        chk(grant_valid && grant_id == 1, "R4 illegal immediate", int'(grant_id), 1);
        after_edge();
        chk(grant_valid == 0, "R10 single-cycle grant", int'(grant_valid), 0);

        // R6: address error waits for a completion
        expq.push_back(3);
        @(negedge clk); addr_err = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); quiet();
            after_edge();
            chk(grant_valid == 0, "R6 address error held without completion", int'(grant_valid), 0);
        end
        @(negedge clk); insn_done = 1;
        after_edge();
        chk(grant_valid && grant_id == 3, "R6 address error at boundary", int'(grant_id), 3);
        idle(1);

        // R5: trace in mode 2 at the same edge; not after a return; not in mode 1
        expq.push_back(2);
        @(negedge clk); trace_bit = 1; icm = 2'd2; insn_done = 1;
        after_edge();
        chk(grant_valid && grant_id == 2, "R5 trace granted", int'(grant_id), 2);
        @(negedge clk); quiet(); insn_done = 1; done_rte = 1;
        after_edge();
        chk(grant_valid == 0, "R5 no trace after return", int'(grant_valid), 0);
        @(negedge clk); quiet(); icm = 2'd1; insn_done = 1;
        after_edge();
        chk(grant_valid == 0, "R5 no trace outside mode 2", int'(grant_valid), 0);
        @(negedge clk); quiet(); trace_bit = 0; icm = 2'd0;
        idle(1);

        // R7: control-register write blocks the interrupt for one boundary
        @(negedge clk); irq_req = 1; insn_done = 1; done_ctl_wr = 1;
        after_edge();
        chk(grant_valid == 0, "R7 interrupt blocked after control write", int'(grant_valid), 0);
        expq.push_back(4);
        @(negedge clk); quiet(); insn_done = 1;
        after_edge();
        chk(grant_valid && grant_id == 4, "R7 interrupt at next boundary", int'(grant_id), 4);
        @(negedge clk); quiet(); irq_req = 0;
        idle(1);

        // R7 and R3: watchdog reset, then first completion blocks the interrupt
        expq.push_back(0);
        @(negedge clk); wdt_ovf = 1;
        @(negedge clk); quiet(); irq_req = 1;
        after_edge();
        chk(grant_valid && grant_id == 0, "R3 watchdog reset immediate", int'(grant_id), 0);
        @(negedge clk); insn_done = 1;
        after_edge();
        chk(grant_valid == 0, "R7 interrupt blocked after reset handling", int'(grant_valid), 0);
        expq.push_back(4);
        @(negedge clk); quiet(); insn_done = 1;
        after_edge();
        chk(grant_valid && grant_id == 4, "R7 interrupt after reset completion", int'(grant_id), 4);
        @(negedge clk); quiet(); irq_req = 0;
        idle(1);

        // R8: sleep gated by the standby bits
        @(negedge clk); sleep_exec = 1; stby_sel = 1; slp_ie = 1;
        @(negedge clk); quiet(); insn_done = 1;
        after_edge();
        chk(grant_valid == 0, "R8 sleep ignored with standby select", int'(grant_valid), 0);
        @(negedge clk); quiet(); sleep_exec = 1; stby_sel = 0; slp_ie = 0;
        @(negedge clk); quiet(); insn_done = 1;
        after_edge();
        chk(grant_valid == 0, "R8 sleep ignored without enable", int'(grant_valid), 0);
        expq.push_back(5);
        @(negedge clk); quiet(); slp_ie = 1; sleep_exec = 1;
        @(negedge clk); quiet(); insn_done = 1;
        after_edge();
        chk(grant_valid && grant_id == 5, "R8 R9 sleep taken at boundary", int'(grant_id), 5);
        idle(1);

        // R9: trap latched, not taken at its own completion edge
        expq.push_back(6);
        @(negedge clk); trap_exec = 1; insn_done = 1;
        after_edge();
        chk(grant_valid == 0, "R9 trap not taken at latching edge", int'(grant_valid), 0);
        @(negedge clk); quiet(); insn_done = 1;
        after_edge();
        chk(grant_valid && grant_id == 6, "R9 trap at next boundary", int'(grant_id), 6);
        idle(1);

        // R11: clear drops the address error but keeps reset
        expq.push_back(0);
        @(negedge clk); addr_err = 1; wdt_ovf = 1;
        @(negedge clk); quiet(); clr_pend = 1; insn_done = 1;
        after_edge();
        chk(grant_valid && grant_id == 0, "R11 reset survives clear", int'(grant_id), 0);
        @(negedge clk); quiet(); insn_done = 1;
        after_edge();
        chk(grant_valid == 0, "R11 address error cleared", int'(grant_valid), 0);
        idle(1);

        // R3: pin low holds core; rising edge requests reset
        @(negedge clk); rst_pin = 0;
        after_edge();
        chk(core_hold == 1, "R3 core_hold while pin low", int'(core_hold), 1);
        chk(grant_valid == 0, "R3 no reset grant while pin low", int'(grant_valid), 0);
        expq.push_back(0);
        @(negedge clk); rst_pin = 1;
        after_edge();
        chk(grant_valid == 0, "R3 reset latched at pin edge", int'(grant_valid), 0);
        after_edge();
        chk(grant_valid && grant_id == 0, "R3 reset granted after pin rise", int'(grant_id), 0);
        // first completion after reset handling
        @(negedge clk); insn_done = 1;
        idle(2);

        // R1 R2: every pair of simultaneous sources
        for (int a = 0; a < 7; a++)
            for (int b = a + 1; b < 7; b++)
                run_pair(a, b);

        idle(4);
        chk(expq.size() == 0, "R2 all pending requests served", expq.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule